// File: doc/BRIEF.md
# Clock-Slave Serial Audio Receiver

This block captures a serial audio stream whose bit clock and frame sync are both driven by an external master. The two lines and the serial data pass through a two-flop synchronizer into the system clock. Each rising bit-clock edge is found from the synchronized copies, and at each such edge one data bit and one frame-sync level are sampled. Two framing styles are supported. In the I2S style, every change of the frame-sync level starts a channel slot. In the DSP-A style, a rising frame sync starts one frame, and the channels follow each other back to back inside it.

Three length fields set the framing, and each holds its length minus one. The data length is the number of bits captured after a boundary. The frame length is the slot size, and bits past it are ignored. The shifter length is the size of each word. A captured run longer than one word is cut into consecutive words, which is how stereo DSP-A frames become two samples. A delay field places the first data bit that many bit clocks after the boundary edge. Finished words leave through a valid/ready stream. A word is held stable until the consumer takes it. If a word finishes while an untaken word is still waiting, the new word is dropped and a sticky overflow flag is raised. Typical settings: 16-bit samples use 16/16/16, 24-bit samples in 32-bit slots use 24/32/24, packed 24-bit samples use 24/24/24, and DSP-A uses sample length times channel count for both data and frame length.

Top module: `slave_audio_rx`

## Requirements
- R1: After reset, m_valid and overflow are 0.
- R2: With i2s_mode=1, each change of the sampled frame-sync level starts a channel slot. Data is taken most significant bit first, starting delay_len rising edges after the boundary edge. A bit that falls on a boundary edge while delay_len is nonzero still completes the word of the slot before it.
- R3: In a slot, only the first min(data_len_m1, frame_len_m1)+1 data bits are captured. Later bits in the slot do not appear in any word.
- R4: With i2s_mode=0, a 0-to-1 change of the sampled frame sync starts a frame. The captured run is cut into words of shift_len_m1+1 bits, in order, so a mono frame gives one word and a stereo frame gives two.
- R5: With delay_len=0, the bit sampled on the boundary edge is the most significant bit of the first word.
- R6: Each word is right-aligned in m_data[31:0], and every bit above the shifter length is 0.
- R7: While m_valid=1 and m_ready=0, m_valid stays 1 and m_data does not change. A transfer happens in each cycle where both are 1.
- R8: If a word completes while m_valid=1 and m_ready=0, that word is dropped, the held word is kept, and overflow becomes 1. Overflow stays 1 while rx_en=1 and returns to 0 one cycle after rx_en is sampled 0.
- R9: While rx_en=0 no bit is captured and no word is produced. After rx_en rises again, capture waits for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Capture enable; low clears framing and overflow |
| i2s_mode | input | 1 | 1: every frame-sync change is a boundary; 0: rising frame sync only |
| data_len_m1 | input | 8 | Captured bits after a boundary, minus one |
| frame_len_m1 | input | 8 | Slot length in bits, minus one |
| shift_len_m1 | input | 5 | Word length in bits, minus one |
| delay_len | input | 8 | Bit clocks from boundary edge to first data bit |
| sclk_in | input | 1 | External bit clock (asynchronous) |
| fsync_in | input | 1 | External frame sync, active high (asynchronous) |
| sdata_in | input | 1 | Serial data (asynchronous) |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream can accept the word |
| m_data | output | 32 | Output word, right-aligned |
| overflow | output | 1 | Sticky: a word was dropped |

## Verification
A rising edge on sclk_in that carries the last bit of a word shows up as m_valid at the fourth system-clock edge after it. Two edges go to the synchronizer, one to the shifter register and one to the output register. The bench holds each bit-clock half period for four system clocks. It records transfers at falling system-clock edges, and it compares counts and words only 20 cycles after the last bit, well beyond that latency. The overflow and stable-hold checks sample a settled output after the same margin. The check that overflow clears waits several cycles after rx_en falls, against a due time of one cycle.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 8;
  localparam int SHL_W   = 5;
  localparam int DLY_W   = 8;
  localparam int POS_W   = LEN_W + 2;
  localparam int CNT_W   = SHL_W;
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_framer.sv
module sar_framer
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             i2s_mode,
  input  logic             sclk_s,
  input  logic             fs_s,
  input  logic [DLY_W-1:0] delay_len,
  input  logic [LEN_W-1:0] data_len_m1,
  input  logic [LEN_W-1:0] frame_len_m1,
  output logic             take,
  output logic             restart,
  output logic             clear_after
);
  logic             sclk_prev, fs_prev, in_frame_q;
  logic [POS_W-1:0] pos_q, pos_inc, take_pos, dly_ext, lim_ext;
  logic             rise, edge_ok, fs_chg, boundary, dly0, take_live, in_win;

  assign rise     = sclk_s & ~sclk_prev;
  assign edge_ok  = rise & en;
  assign fs_chg   = i2s_mode ? (fs_s != fs_prev) : (fs_s & ~fs_prev);
  assign boundary = edge_ok & fs_chg;
  assign dly0     = (delay_len == '0);

  always_comb begin
    pos_inc   = (pos_q == POS_MAX) ? pos_q : pos_q + 1'b1;
    take_pos  = (boundary && dly0) ? '0 : pos_inc;
    take_live = (boundary && dly0) || in_frame_q;
    dly_ext   = POS_W'(delay_len);
    lim_ext   = (data_len_m1 < frame_len_m1) ? POS_W'(data_len_m1)
                                             : POS_W'(frame_len_m1);
    in_win    = (take_pos >= dly_ext) && ((take_pos - dly_ext) <= lim_ext);
  end

  assign take        = edge_ok & take_live & in_win;
  assign restart     = boundary & dly0;
  assign clear_after = boundary & ~dly0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev  <= 1'b0;
      fs_prev    <= 1'b0;
      in_frame_q <= 1'b0;
      pos_q      <= '0;
    end else begin
      sclk_prev <= sclk_s;
      if (rise) fs_prev <= fs_s;
      if (!en) begin
        in_frame_q <= 1'b0;
        pos_q      <= '0;
      end else if (boundary) begin
        in_frame_q <= 1'b1;
        pos_q      <= '0;
      end else if (edge_ok) begin
        pos_q <= pos_inc;
      end
    end
  end
endmodule

// File: rtl/sar_shifter.sv
module sar_shifter
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              take,
  input  logic              restart,
  input  logic              clear_after,
  input  logic              bit_in,
  input  logic [SHL_W-1:0]  shift_len_m1,
  output logic              push_q,
  output logic [WORD_W-1:0] word_q
);
  logic [WORD_W-1:0] sh_q, base_sh, nsh;
  logic [CNT_W-1:0]  cnt_q, base_cnt;
  logic              full;

  always_comb begin
    base_sh  = restart ? '0 : sh_q;
    base_cnt = restart ? '0 : cnt_q;
    nsh      = {base_sh[WORD_W-2:0], bit_in};
    full     = take && (base_cnt == shift_len_m1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      push_q <= 1'b0;
      word_q <= '0;
    end else if (!en) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      push_q <= 1'b0;
    end else begin
      push_q <= full;
      if (full) word_q <= nsh;
      if (clear_after || full) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end else if (take) begin
        sh_q  <= nsh;
        cnt_q <= base_cnt + 1'b1;
      end else if (restart) begin
        sh_q  <= '0;
        cnt_q <= '0;
      end
    end
  end

  // R9
  no_push_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !push_q);

  // R6
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_q |-> ((word_q >> ({1'b0, shift_len_m1} + 6'd1)) == '0));
endmodule

// File: rtl/sar_outreg.sv
module sar_outreg
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [WORD_W-1:0] m_data,
  output logic              overflow
);
  logic blocked;
  assign blocked = m_valid & ~m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data   <= '0;
      overflow <= 1'b0;
    end else begin
      if (push && !blocked) begin
        m_valid <= 1'b1;
        m_data  <= word;
      end else if (m_valid && m_ready) begin
        m_valid <= 1'b0;
      end
      if (!en) overflow <= 1'b0;
      else if (push && blocked) overflow <= 1'b1;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R8
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && push && m_valid && !m_ready) |=> overflow);

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && overflow) |=> overflow);
endmodule

// File: rtl/slave_audio_rx.sv
module slave_audio_rx
  import sar_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              i2s_mode,
  input  logic [LEN_W-1:0]  data_len_m1,
  input  logic [LEN_W-1:0]  frame_len_m1,
  input  logic [SHL_W-1:0]  shift_len_m1,
  input  logic [DLY_W-1:0]  delay_len,
  input  logic              sclk_in,
  input  logic              fsync_in,
  input  logic              sdata_in,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [WORD_W-1:0] m_data,
  output logic              overflow
);
  logic [2:0]        pins_s;
  logic              take, restart, clear_after, push;
  logic [WORD_W-1:0] word;

  sar_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdata_in, fsync_in, sclk_in}), .q(pins_s)
  );

  sar_framer u_framer (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .i2s_mode(i2s_mode),
    .sclk_s(pins_s[0]), .fs_s(pins_s[1]), .delay_len(delay_len),
    .data_len_m1(data_len_m1), .frame_len_m1(frame_len_m1),
    .take(take), .restart(restart), .clear_after(clear_after)
  );

  sar_shifter u_shifter (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .take(take), .restart(restart),
    .clear_after(clear_after), .bit_in(pins_s[2]),
    .shift_len_m1(shift_len_m1), .push_q(push), .word_q(word)
  );

  sar_outreg u_out (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .push(push), .word(word),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .overflow(overflow)
  );
endmodule

// File: tb/tb_slave_audio_rx.sv
`timescale 1ns/1ps
module tb_slave_audio_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0, i2s_mode = 1'b0;
  logic [7:0]  data_len_m1 = '0, frame_len_m1 = '0, delay_len = '0;
  logic [4:0]  shift_len_m1 = '0;
  logic        sclk_in = 1'b0, fsync_in = 1'b0, sdata_in = 1'b0;
  logic        m_ready = 1'b1;
  logic        m_valid, overflow;
  logic [31:0] m_data;

  always #2.5 clk = ~clk;

  slave_audio_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .i2s_mode(i2s_mode),
    .data_len_m1(data_len_m1), .frame_len_m1(frame_len_m1),
    .shift_len_m1(shift_len_m1), .delay_len(delay_len),
    .sclk_in(sclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .overflow(overflow)
  );

  typedef struct packed {
    logic        i2s;
    logic [5:0]  slen;
    logic [5:0]  slot;
    logic [1:0]  nch;
    logic [7:0]  dly;
    logic [31:0] s0;
    logic [31:0] s1;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'd16, 6'd16, 2'd2, 8'd1, 32'h0000A5C3, 32'h00005A3C},
    '{1'b1, 6'd24, 6'd32, 2'd2, 8'd1, 32'h00123456, 32'h00FEDCBA},
    '{1'b1, 6'd24, 6'd24, 2'd2, 8'd1, 32'h00800001, 32'h007FFFFE},
    '{1'b0, 6'd16, 6'd16, 2'd1, 8'd1, 32'h0000BEEF, 32'h00000000},
    '{1'b0, 6'd16, 6'd16, 2'd2, 8'd1, 32'h00001234, 32'h0000CDEF},
    '{1'b0, 6'd24, 6'd24, 2'd2, 8'd0, 32'h00ABCDEF, 32'h00012345},
    '{1'b1, 6'd16, 6'd32, 2'd2, 8'd0, 32'h00008001, 32'h0000C3C3}
  };

  int          errors = 0, checks = 0;
  logic [31:0] rx_log [64];
  int          rx_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      if (rx_cnt < 64) rx_log[rx_cnt] <= m_data;
      rx_cnt <= rx_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sys_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_edge(input logic fs, input logic sd);
    sclk_in = 1'b0; fsync_in = fs; sdata_in = sd;
    sys_wait(4);
    sclk_in = 1'b1;
    sys_wait(4);
  endtask

  task automatic send_frame(input logic i2s, input int slen, input int slot,
                            input int nch, input int dly,
                            input logic [31:0] s0, input logic [31:0] s1);
    logic fs_a [128];
    logic sd_a [128];
    int   n;
    logic [31:0] smp;
    if (i2s) begin
      n = 2 + 2*slot + dly + 3;
      for (int e = 0; e < 128; e++) begin
        fs_a[e] = (e < 2) ? 1'b1 : (e < 2+slot) ? 1'b0
                : (e < 2+2*slot) ? 1'b1 : 1'b0;
        sd_a[e] = (e >= 2);
      end
      for (int c = 0; c < 2; c++) begin
        smp = c ? s1 : s0;
        for (int k = 0; k < slen; k++)
          sd_a[2 + c*slot + dly + k] = smp[slen-1-k];
      end
    end else begin
      n = 2 + dly + slen*nch + 3;
      for (int e = 0; e < 128; e++) begin
        fs_a[e] = (e == 2);
        sd_a[e] = 1'b0;
      end
      for (int c = 0; c < nch; c++) begin
        smp = c ? s1 : s0;
        for (int k = 0; k < slen; k++)
          sd_a[2 + dly + c*slen + k] = smp[slen-1-k];
      end
    end
    for (int e = 0; e < n; e++) bit_edge(fs_a[e], sd_a[e]);
    sclk_in = 1'b0;
  endtask

  task automatic configure(input logic i2s, input int slen, input int slot,
                           input int nch, input int dly);
    i2s_mode     = i2s;
    data_len_m1  = 8'(i2s ? slen - 1 : slen*nch - 1);
    frame_len_m1 = 8'(i2s ? slot - 1 : slen*nch - 1);
    shift_len_m1 = 5'(slen - 1);
    delay_len    = 8'(dly);
  endtask

  initial begin : main
    int base;
    int nexp;
    string tag;
    logic [31:0] mask, expw;
    sys_wait(5);
    // R1: reset state
    check("R1 m_valid", {31'd0, m_valid}, 32'd0);
    check("R1 overflow", {31'd0, overflow}, 32'd0);
    rst_n = 1'b1;
    sys_wait(3);

    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      if (t.dly == 0) tag = "R5";
      else if (t.i2s && t.slot > t.slen) tag = "R3";
      else tag = t.i2s ? "R2" : "R4";
      configure(t.i2s, int'(t.slen), int'(t.slot), int'(t.nch), int'(t.dly));
      base = rx_cnt;
      rx_en = 1'b1;
      send_frame(t.i2s, int'(t.slen), int'(t.slot), int'(t.nch), int'(t.dly),
                 t.s0, t.s1);
      sys_wait(20);
      nexp = int'(t.nch);
      check({tag, " word count"}, 32'(rx_cnt - base), 32'(nexp));
      mask = (t.slen == 32) ? 32'hFFFFFFFF : ((32'd1 << t.slen) - 1);
      for (int i = 0; i < nexp; i++) begin
        expw = (i == 0 ? t.s0 : t.s1) & mask;
        check({tag, " word"}, rx_log[base+i], expw);
        check("R6 upper bits zero", rx_log[base+i] & ~mask, 32'd0);
      end
      rx_en = 1'b0;
      sys_wait(4);
    end

    // R9: disabled receiver ignores a full frame
    configure(1'b0, 16, 16, 2, 1);
    base = rx_cnt;
    send_frame(1'b0, 16, 16, 2, 1, 32'h1111, 32'h2222);
    sys_wait(20);
    check("R9 no words while off", 32'(rx_cnt - base), 32'd0);
    check("R9 m_valid low", {31'd0, m_valid}, 32'd0);

    // R8/R7: second word dropped while first is held
    m_ready = 1'b0;
    rx_en = 1'b1;
    base = rx_cnt;
    send_frame(1'b0, 16, 16, 2, 1, 32'h0000ABCD, 32'h00004321);
    sys_wait(20);
    check("R8 overflow set", {31'd0, overflow}, 32'd1);
    check("R7 held valid", {31'd0, m_valid}, 32'd1);
    check("R7 held data", m_data, 32'h0000ABCD);
    sys_wait(10);
    check("R8 overflow sticky", {31'd0, overflow}, 32'd1);
    check("R7 data still held", m_data, 32'h0000ABCD);
    m_ready = 1'b1;
    sys_wait(6);
    check("R7 one transfer", 32'(rx_cnt - base), 32'd1);
    check("R8 kept word", rx_log[base], 32'h0000ABCD);
    rx_en = 1'b0;
    sys_wait(4);
    check("R8 cleared by disable", {31'd0, overflow}, 32'd0);

    // R9: after re-enable, a frame still captures normally
    rx_en = 1'b1;
    base = rx_cnt;
    send_frame(1'b0, 16, 16, 1, 1, 32'h00007E81, 32'h0);
    sys_wait(20);
    check("R9 capture after re-enable", 32'(rx_cnt - base), 32'd1);
    check("R9 word after re-enable", rx_log[base], 32'h00007E81);
    rx_en = 1'b0;
    sys_wait(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule